// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit up-counting timer behind a small synchronous register port. A prescaler divides the system clock by an 8-bit programmable value plus one. One clock-source setting adds a further divide-by-16 stage. Each prescaled tick advances the counter. When the counter reaches the reference value, a sticky reference flag is set in the event register. If restart is enabled, the count goes back to zero on the next tick. The interrupt output follows the reference flag whenever the interrupt enable bit is set.

Software programs the reference value and then the mode word, which holds the enable, the clock source, restart, the interrupt enable and the prescale value. It clears the flag by writing ones to the event register. Software can also preload or read the count at any time. The capture-edge and output-mode bits are stored only; no pin logic uses them.

Top module: `ref_cmp_timer`

## Requirements
- R1: After reset, every register (mode, reference, capture, count, event) reads zero and `irq` is low.
- R2: Mode bits 15:8 hold P. With mode bits 2:1 = 1, the count advances once every P+1 clocks. With mode bits 2:1 = 2, it advances once every 16*(P+1) clocks. Each period is counted from the write that started the timer.
- R3: The count does not advance while mode bit 0 (enable) is 0, or while mode bits 2:1 are 0 or 3.
- R4: When a prescaled tick brings the count to the reference value, event bit 1 is set. It stays set until software clears it. Event bit 0 (capture flag) is never set by the block.
- R5: A write to the event register clears each event bit written as 1. Bits written as 0 are unaffected.
- R6: `irq` is high exactly when mode bit 4 and event bit 1 are both set.
- R7: A mode write that changes mode bit 0 from 1 to 0 sets both the mode register and the reference register to zero, whatever value was written.
- R8: Byte offsets are 0x00 mode, 0x04 reference, 0x08 capture, 0x0C count and 0x11 event. Mode, reference and capture read back what was written. Reads of any other offset return zero.
- R9: With mode bit 3 set, the tick after the count equals the reference value returns the count to 0. With bit 3 clear, the count keeps incrementing past the reference and wraps at 16 bits.
- R10: Any write to mode or reference zeroes both the prescaler and the count. A write to the count offset loads the written value, and counting then continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | AW (5) | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Reference interrupt request |

## Verification
A wrong prescaler state shows as a count that changes one or more clocks too early or too late. The bench therefore samples the count on the exact clock before and after each expected step. A wrong match or restart decision shows within one tick, as a count that fails to return to zero, or as an event flag and `irq` that appear or stay missing on the cycle the count reaches the reference. A write that clears the wrong state shows at the next read of mode, reference or event.

// File: rtl/ref_cmp_timer.sv
module ref_cmp_timer #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_MODE = AW'(5'h00);
  localparam logic [AW-1:0] A_REF  = AW'(5'h04);
  localparam logic [AW-1:0] A_CAP  = AW'(5'h08);
  localparam logic [AW-1:0] A_CNT  = AW'(5'h0C);
  localparam logic [AW-1:0] A_EVT  = AW'(5'h11);

  logic [15:0] mode, refv, capv, cnt;
  logic [1:0]  evt;
  logic [11:0] psc;

  wire wr_mode = bus_wr && bus_addr == A_MODE;
  wire wr_ref  = bus_wr && bus_addr == A_REF;
  wire wr_cap  = bus_wr && bus_addr == A_CAP;
  wire wr_cnt  = bus_wr && bus_addr == A_CNT;
  wire wr_evt  = bus_wr && bus_addr == A_EVT;

  wire        en_fall = wr_mode && mode[0] && !bus_wdata[0];
  wire        restart = wr_mode || wr_ref;
  wire [1:0]  src     = mode[2:1];
  wire        run     = mode[0] && (src == 2'd1 || src == 2'd2);
  wire [11:0] lim     = (src == 2'd2) ? {mode[15:8], 4'hF} : {4'h0, mode[15:8]};
  wire        tick    = run && psc == lim;
  wire        wrap    = mode[3] && cnt == refv;
  wire [15:0] cnt_nxt = wrap ? 16'd0 : cnt + 16'd1;
  wire        hit     = tick && !restart && !wr_cnt && cnt_nxt == refv;
  wire [1:0]  clr     = wr_evt ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)                 psc <= '0;
    else if (restart || !run)   psc <= '0;
    else if (tick)              psc <= '0;
    else                        psc <= psc + 12'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (wr_cnt)   cnt <= bus_wdata;
    else if (tick)     cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      refv <= '0;
      capv <= '0;
      evt  <= '0;
    end else begin
      if (wr_mode) mode <= en_fall ? 16'd0 : bus_wdata;
      if (en_fall)     refv <= '0;
      else if (wr_ref) refv <= bus_wdata;
      if (wr_cap) capv <= bus_wdata;
      evt <= (evt & ~clr) | {hit, 1'b0};
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode;
      A_REF:   bus_rdata = refv;
      A_CAP:   bus_rdata = capv;
      A_CNT:   bus_rdata = cnt;
      A_EVT:   bus_rdata = {14'd0, evt};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = mode[4] & evt[1];
endmodule

// File: rtl/ref_cmp_timer_chk.sv
module ref_cmp_timer_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   mode,
  input logic [15:0]   refv,
  input logic [15:0]   cnt,
  input logic [1:0]    evt,
  input logic          tick
);
  localparam logic [AW-1:0] C_MODE = AW'(5'h00);
  localparam logic [AW-1:0] C_EVT  = AW'(5'h11);

  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && !bus_wr) |=> $stable(cnt));

  p_flag_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt[1]) |-> $past(tick));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_EVT && bus_wdata[1] && !tick) |=> !evt[1]);

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_MODE && mode[0] && !bus_wdata[0]) |=> (mode == 16'd0 && refv == 16'd0));

  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode[3] && cnt == refv && !bus_wr) |=> cnt == 16'd0);
endmodule

bind ref_cmp_timer ref_cmp_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mode(mode), .refv(refv), .cnt(cnt),
  .evt(evt), .tick(tick)
);

// File: tb/test_ref_cmp_timer.sv
`timescale 1ns/1ps
module test_ref_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ref_cmp_timer #(.AW(5)) i_ref_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(5'h00, v); check("R1 mode", v, 16'h0);
    rd(5'h04, v); check("R1 ref", v, 16'h0);
    rd(5'h08, v); check("R1 cap", v, 16'h0);
    rd(5'h0C, v); check("R1 cnt", v, 16'h0);
    rd(5'h11, v); check("R1 evt", v, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(5'h04, 16'h1234); rd(5'h04, v); check("R8 ref readback", v, 16'h1234);
    wr(5'h08, 16'hBEEF); rd(5'h08, v); check("R8 cap readback", v, 16'hBEEF);
    wr(5'h00, 16'hAB00); rd(5'h00, v); check("R8 mode readback", v, 16'hAB00);
    rd(5'h14, v); check("R8 unmapped", v, 16'h0);
    rd(5'h10, v); check("R8 unmapped 0x10", v, 16'h0);
    wr(5'h00, 16'h0000);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    wr(5'h04, 16'd100);
    wr(5'h00, 16'h0303);
    wait_clks(3); rd(5'h0C, v); check("R2 P=3 before step", v, 16'd0);
    wait_clks(1); rd(5'h0C, v); check("R2 P=3 first step", v, 16'd1);
    wait_clks(16); rd(5'h0C, v); check("R2 P=3 five steps", v, 16'd5);
    wr(5'h00, 16'h0105);
    rd(5'h0C, v); check("R10 mode write zeroes count", v, 16'd0);
    wait_clks(31); rd(5'h0C, v); check("R2 div16 before step", v, 16'd0);
    wait_clks(1); rd(5'h0C, v); check("R2 div16 first step", v, 16'd1);
    wr(5'h04, 16'd90);
    rd(5'h0C, v); check("R10 ref write zeroes count", v, 16'd0);
    wait_clks(31); rd(5'h0C, v); check("R10 prescaler restarted", v, 16'd0);
    wait_clks(1); rd(5'h0C, v); check("R10 step after ref write", v, 16'd1);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr(5'h00, 16'h0001);
    wait_clks(40); rd(5'h0C, v); check("R3 src0 stopped", v, 16'd0);
    wr(5'h00, 16'h0007);
    wait_clks(40); rd(5'h0C, v); check("R3 src3 stopped", v, 16'd0);
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h0002);
    wr(5'h0C, 16'd7);
    wait_clks(40); rd(5'h0C, v); check("R3 disabled holds", v, 16'd7);
  endtask

  task automatic t_match;
    logic [15:0] v;
    wr(5'h04, 16'd3);
    wr(5'h00, 16'h001B);
    wait_clks(2); rd(5'h0C, v); check("R4 count 2", v, 16'd2);
    rd(5'h11, v); check("R4 no flag yet", v, 16'd0);
    check("R6 irq low", {15'd0, irq}, 16'd0);
    wait_clks(1); rd(5'h0C, v); check("R4 count at ref", v, 16'd3);
    rd(5'h11, v); check("R4 flag set", v, 16'd2);
    check("R6 irq high", {15'd0, irq}, 16'd1);
    wait_clks(1); rd(5'h0C, v); check("R9 restart to 0", v, 16'd0);
    wr(5'h00, 16'h0019);
    rd(5'h11, v); check("R4 flag sticky", v, 16'd2);
    wr(5'h11, 16'h0001);
    rd(5'h11, v); check("R5 zero bit ignored", v, 16'd2);
    check("R6 irq still high", {15'd0, irq}, 16'd1);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); check("R5 cleared", v, 16'd0);
    check("R6 irq low after clear", {15'd0, irq}, 16'd0);
    wr(5'h00, 16'h000B);
    wait_clks(3); rd(5'h11, v); check("R4 flag again", v, 16'd2);
    check("R6 irq masked", {15'd0, irq}, 16'd0);
    wr(5'h00, 16'h0019);
    check("R6 irq enabled", {15'd0, irq}, 16'd1);
    wr(5'h11, 16'h0003);
  endtask

  task automatic t_norestart;
    logic [15:0] v;
    wr(5'h00, 16'h0003);
    wr(5'h04, 16'd2);
    wait_clks(4); rd(5'h0C, v); check("R9 passes ref", v, 16'd4);
    rd(5'h11, v); check("R4 flag no restart", v, 16'd2);
    wr(5'h0C, 16'h0050);
    rd(5'h0C, v); check("R10 load", v, 16'h0050);
    wait_clks(1); rd(5'h0C, v); check("R10 count after load", v, 16'h0051);
    wr(5'h0C, 16'hFFFF);
    wait_clks(1); rd(5'h0C, v); check("R9 wrap", v, 16'h0000);
  endtask

  task automatic t_disable;
    logic [15:0] v;
    wr(5'h04, 16'h0055);
    wr(5'h00, 16'h1213);
    wr(5'h00, 16'hFF12);
    rd(5'h00, v); check("R7 mode cleared", v, 16'h0);
    rd(5'h04, v); check("R7 ref cleared", v, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_prescale();
    t_stop();
    t_match();
    t_norestart();
    t_disable();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule